// File: doc/BRIEF.md
# Frame Pattern-Checksum Receive Filter

This block sits beside a receive path and watches the bytes of an Ethernet frame as they arrive, counting from the first byte of the destination address. A configurable 64-byte window, placed at an offset inside the first 128 bytes, is scanned. A 64-bit mask keeps or drops each byte in that window. The kept bytes are summed with the Internet ones'-complement checksum, and the result is compared with an expected value. The comparison can be inverted. It is then qualified by a mode code that can demand extra conditions from neighbouring filters, such as a broadcast flag, a hash-table hit or a multicast flag.

Dropped bytes are removed from the stream before the kept bytes are paired into 16-bit words, so each dropped byte shifts the pairing of every byte after it. A frame that ends before the last window byte never matches. The configuration is captured on the start-of-frame byte. One cycle after the end-of-frame byte, the block gives a single accept or reject verdict, marked by a one-cycle valid pulse.

The control is a three-state machine:
- IDLE waits for a start byte.
- FRAME consumes bytes.
- REPORT presents the verdict for one cycle.

The transitions are:
- IDLE→FRAME on a start byte.
- IDLE→REPORT on a one-byte frame, where start and end come together.
- FRAME→REPORT on an end byte.
- FRAME→FRAME on a start byte, which restarts the frame.
- REPORT→IDLE when no start byte is present.
- REPORT→FRAME or REPORT→REPORT when a new frame starts in the report cycle.

Top module: `pmf_filter_top`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0, and the latched mode is 0000 (disabled).
- R2: `dec_valid` is high for exactly one cycle, the cycle after the clock edge that takes the end-of-frame byte (`rx_valid` and `rx_eof` both high). `dec_accept` is high only while `dec_valid` is high.
- R3: Byte index 0 is the start-of-frame byte. The window covers the indices `cfg_offset` through `cfg_offset`+63. Bytes outside the window never affect the checksum.
- R4: Mask bit k (bit 0 is the first window byte) keeps window byte k when it is 1. A byte whose mask bit is 0 is removed before pairing, so it changes neither the sum nor the pairing of later bytes.
- R5: Kept bytes are paired big-endian: the first byte of a pair is bits 15:8. An odd last byte is padded with a zero low byte. Words are added with end-around carry, and the checksum is the complement of the sum. Offset 0 with mask bits 6 to 11 over source address 00-04-A3-FF-FF-FF gives 5BFC. The raw match is checksum == `cfg_expect`.
- R6: `cfg_invert`=1 turns the raw match into a mismatch and a mismatch into a match.
- R7: If the frame ends before window byte 63, the pattern result is false. This holds even with an all-zero mask and even with `cfg_invert`=1.
- R8: The offset value 1 is unsupported, and it always gives a false pattern result.
- R9: Mode 0000 rejects every frame. Modes 0101 to 1111 are reserved and also reject.
- R10: Mode 0001 accepts on the pattern result alone. Mode 0010 also requires `cond_hash`, 0011 also requires `cond_bcast`, and 0100 also requires `cond_mcast`. The conditions are sampled with the end-of-frame byte.
- R11: Configuration is sampled with the start-of-frame byte. Changes later in the frame do not affect that frame's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_offset | input | 6 | Window start index (0, 2..63) |
| cfg_mask | input | 64 | Per-byte keep mask for the window |
| cfg_expect | input | 16 | Expected checksum |
| cfg_invert | input | 1 | Invert the raw match |
| cfg_mode | input | 4 | Enable / combining code |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Received byte |
| cond_bcast | input | 1 | Broadcast condition from another filter |
| cond_hash | input | 1 | Hash-table hit from another filter |
| cond_mcast | input | 1 | Multicast condition from another filter |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Frame accepted |

## Verification
The bench builds the block with its default parameters: a 64-byte window and a 128-byte span. These place the window end at any index up to 126 and let the 7-bit byte index saturate within a 300-byte frame. With these values the bench reaches the window placed at the last legal offset (63), with a frame that ends exactly on the last window byte. It also reaches the example frame at both offset 0 and offset 6, including the 69-byte frame that must fail at offset 6.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FRAME  = 2'd1,
        ST_REPORT = 2'd2
    } pmf_state_e;

    localparam logic [3:0] MODE_OFF   = 4'd0;
    localparam logic [3:0] MODE_PAT   = 4'd1;
    localparam logic [3:0] MODE_HASH  = 4'd2;
    localparam logic [3:0] MODE_BCAST = 4'd3;
    localparam logic [3:0] MODE_MCAST = 4'd4;

    // ones'-complement add with end-around carry
    function automatic logic [WORD_W-1:0] oc_add(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b);
        logic [WORD_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]};
    endfunction

endpackage

// File: rtl/pmf_window.sv
module pmf_window #(
    parameter int WIN_BYTES  = 64,
    parameter int SPAN_BYTES = 128,
    parameter int OFS_W      = $clog2(SPAN_BYTES - WIN_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 step,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [WIN_BYTES-1:0] mask,
    output logic                 incl,
    output logic                 win_done
);
    localparam int IDX_W = $clog2(SPAN_BYTES);
    localparam int WB_W  = $clog2(WIN_BYTES);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(SPAN_BYTES - 1);

    logic [IDX_W-1:0] idx_q, cur_idx, ofs_x, win_end;
    logic [WB_W-1:0]  rel;
    logic             full_q, in_win, last_hit;

    assign cur_idx  = start ? '0 : idx_q;
    assign ofs_x    = IDX_W'(ofs);
    assign win_end  = ofs_x + IDX_W'(WIN_BYTES - 1);
    assign rel      = WB_W'(cur_idx - ofs_x);
    assign in_win   = (cur_idx >= ofs_x) && (cur_idx <= win_end);
    assign incl     = step && in_win && mask[rel];
    assign last_hit = step && (cur_idx == win_end);
    assign win_done = (full_q && !start) || last_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (step) begin
            idx_q  <= (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
            full_q <= start ? last_hit : (full_q || last_hit);
        end
    end

    // once the last window byte is seen, the flag stays until the next frame
    p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !start) |=> full_q);

endmodule

// File: rtl/pmf_csum.sv
module pmf_csum
    import pmf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] csum_now
);
    logic [WORD_W-1:0] sum_q, b_sum, n_sum, tot;
    logic [7:0]        hi_q, b_hi, n_hi;
    logic              pend_q, b_pend, n_pend;

    always_comb begin
        b_sum  = clr ? '0   : sum_q;
        b_hi   = clr ? '0   : hi_q;
        b_pend = clr ? 1'b0 : pend_q;
        n_sum  = b_sum;
        n_hi   = b_hi;
        n_pend = b_pend;
        if (take) begin
            if (b_pend) begin
                n_sum  = oc_add(b_sum, {b_hi, byte_in});
                n_pend = 1'b0;
            end else begin
                n_hi   = byte_in;
                n_pend = 1'b1;
            end
        end
        tot      = n_pend ? oc_add(n_sum, {n_hi, 8'h00}) : n_sum;
        csum_now = ~tot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q  <= '0;
            hi_q   <= '0;
            pend_q <= 1'b0;
        end else if (clr || take) begin
            sum_q  <= n_sum;
            hi_q   <= n_hi;
            pend_q <= n_pend;
        end
    end

    p_hold_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !take) |=> ($stable(sum_q) && $stable(pend_q)));

    p_pair_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && take && !pend_q) |=> pend_q);

endmodule

// File: rtl/pmf_combine.sv
module pmf_combine
    import pmf_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              pat,
    input  logic              bcast,
    input  logic              hash,
    input  logic              mcast,
    output logic              accept
);
    always_comb begin
        case (mode)
            MODE_PAT:   accept = pat;
            MODE_HASH:  accept = pat && hash;
            MODE_BCAST: accept = pat && bcast;
            MODE_MCAST: accept = pat && mcast;
            default:    accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmf_filter_top.sv
module pmf_filter_top
    import pmf_pkg::*;
#(
    parameter int WIN_BYTES  = 64,
    parameter int SPAN_BYTES = 128,
    parameter int MODE_W     = 4,
    parameter int OFS_W      = $clog2(SPAN_BYTES - WIN_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OFS_W-1:0]     cfg_offset,
    input  logic [WIN_BYTES-1:0] cfg_mask,
    input  logic [WORD_W-1:0]    cfg_expect,
    input  logic                 cfg_invert,
    input  logic [MODE_W-1:0]    cfg_mode,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic [7:0]           rx_data,
    input  logic                 cond_bcast,
    input  logic                 cond_hash,
    input  logic                 cond_mcast,
    output logic                 dec_valid,
    output logic                 dec_accept
);
    localparam logic [OFS_W-1:0] OFS_BAD = OFS_W'(1);

    pmf_state_e state_q, state_d;

    logic [OFS_W-1:0]     lat_ofs, eff_ofs;
    logic [WIN_BYTES-1:0] lat_mask, eff_mask;
    logic [WORD_W-1:0]    lat_exp, eff_exp, csum;
    logic                 lat_inv, eff_inv;
    logic [MODE_W-1:0]    lat_mode, eff_mode;
    logic                 frame_start, step, end_now, incl, win_done, pat, acc;
    logic                 acc_q;

    assign frame_start = rx_valid && rx_sof;
    assign step        = rx_valid && (rx_sof || state_q == ST_FRAME);
    assign end_now     = step && rx_eof;

    // configuration in force for this byte: live on the start byte, latched after
    assign eff_ofs  = frame_start ? cfg_offset : lat_ofs;
    assign eff_mask = frame_start ? cfg_mask   : lat_mask;
    assign eff_exp  = frame_start ? cfg_expect : lat_exp;
    assign eff_inv  = frame_start ? cfg_invert : lat_inv;
    assign eff_mode = frame_start ? cfg_mode   : lat_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_ofs  <= '0;
            lat_mask <= '0;
            lat_exp  <= '0;
            lat_inv  <= 1'b0;
            lat_mode <= MODE_OFF;
        end else if (frame_start) begin
            lat_ofs  <= cfg_offset;
            lat_mask <= cfg_mask;
            lat_exp  <= cfg_expect;
            lat_inv  <= cfg_invert;
            lat_mode <= cfg_mode;
        end
    end

    pmf_window #(
        .WIN_BYTES (WIN_BYTES),
        .SPAN_BYTES(SPAN_BYTES),
        .OFS_W     (OFS_W)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (frame_start),
        .step    (step),
        .ofs     (eff_ofs),
        .mask    (eff_mask),
        .incl    (incl),
        .win_done(win_done)
    );

    pmf_csum u_csum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (frame_start),
        .take    (incl),
        .byte_in (rx_data),
        .csum_now(csum)
    );

    assign pat = win_done && (eff_ofs != OFS_BAD) && ((csum == eff_exp) ^ eff_inv);

    pmf_combine #(.MODE_W(MODE_W)) u_combine (
        .mode  (eff_mode),
        .pat   (pat),
        .bcast (cond_bcast),
        .hash  (cond_hash),
        .mcast (cond_mcast),
        .accept(acc)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = rx_eof ? ST_REPORT : ST_FRAME;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_FRAME:  state_d = (rx_valid && rx_eof) ? ST_REPORT : ST_FRAME;
                ST_REPORT: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= 1'b0;
        else if (end_now) acc_q <= acc;
        else              acc_q <= 1'b0;
    end

    assign dec_valid  = (state_q == ST_REPORT);
    assign dec_accept = dec_valid && acc_q;

    p_valid_after_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid && rx_eof));

    p_accept_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    p_off_rejects_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (end_now && eff_mode == MODE_OFF) |=> !dec_accept);

    p_bad_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_now && eff_ofs == OFS_BAD) |=> !dec_accept);

endmodule

// File: tb/test_pmf_filter_top.sv
`timescale 1ns/1ps
module test_pmf_filter_top;

    typedef struct packed {
        logic        kind;   // 1: example frame with fixed address bytes
        logic [5:0]  ofs;
        logic [63:0] mask;
        logic        inv;
        logic [3:0]  mode;
        logic        bc;
        logic        hs;
        logic        mc;
        logic [8:0]  len;
        logic [7:0]  seed;
        logic        hit;    // program the matching checksum
        logic        acc;    // expected verdict
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 6'd0,  64'h0000_0000_0000_0FC0, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd64,  8'd1,  1'b1, 1'b1}, // R5 example
        '{1'b1, 6'd6,  64'h0000_0000_0000_003F, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd70,  8'd1,  1'b1, 1'b1}, // R3 shifted window
        '{1'b1, 6'd6,  64'h0000_0000_0000_003F, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd69,  8'd1,  1'b1, 1'b0}, // R7 short
        '{1'b0, 6'd2,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd100, 8'd5,  1'b1, 1'b1}, // R5 full mask
        '{1'b0, 6'd2,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd100, 8'd5,  1'b0, 1'b0}, // R5 mismatch
        '{1'b0, 6'd2,  64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 9'd100, 8'd5,  1'b0, 1'b1}, // R6
        '{1'b0, 6'd2,  64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 9'd100, 8'd5,  1'b1, 1'b0}, // R6
        '{1'b0, 6'd0,  64'h0,                   1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 9'd63,  8'd9,  1'b0, 1'b0}, // R7 empty mask
        '{1'b0, 6'd0,  64'h0,                   1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd64,  8'd9,  1'b1, 1'b1}, // R7 complete
        '{1'b0, 6'd1,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd100, 8'd3,  1'b1, 1'b0}, // R8
        '{1'b0, 6'd63, 64'h5555_5555_5555_5555, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd127, 8'd7,  1'b1, 1'b1}, // R4
        '{1'b0, 6'd4,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 9'd90,  8'd2,  1'b1, 1'b0}, // R9
        '{1'b0, 6'd4,  64'h00FF_00FF_00FF_00FF, 1'b0, 4'd2, 1'b0, 1'b1, 1'b0, 9'd90,  8'd4,  1'b1, 1'b1}, // R10 hash
        '{1'b0, 6'd4,  64'h00FF_00FF_00FF_00FF, 1'b0, 4'd2, 1'b1, 1'b0, 1'b1, 9'd90,  8'd4,  1'b1, 1'b0}, // R10 no hash
        '{1'b0, 6'd4,  64'h00FF_00FF_00FF_00FF, 1'b0, 4'd3, 1'b1, 1'b0, 1'b0, 9'd90,  8'd4,  1'b1, 1'b1}, // R10 bcast
        '{1'b0, 6'd4,  64'h00FF_00FF_00FF_00FF, 1'b0, 4'd4, 1'b1, 1'b1, 1'b0, 9'd90,  8'd4,  1'b1, 1'b0}, // R10 no mcast
        '{1'b0, 6'd4,  64'h00FF_00FF_00FF_00FF, 1'b0, 4'd7, 1'b1, 1'b1, 1'b1, 9'd90,  8'd4,  1'b1, 1'b0}, // R9 reserved
        '{1'b0, 6'd10, 64'h0000_0000_0000_0007, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd80,  8'd6,  1'b1, 1'b1}, // R5 odd count
        '{1'b0, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 9'd300, 8'd8,  1'b1, 1'b1}  // R3 long frame
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_offset = '0;
    logic [63:0] cfg_mask = '0;
    logic [15:0] cfg_expect = '0;
    logic        cfg_invert = 1'b0;
    logic [3:0]  cfg_mode = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        cond_bcast = 1'b0, cond_hash = 1'b0, cond_mcast = 1'b0;
    logic        dec_valid, dec_accept;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pmf_filter_top i_pmf_filter_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_offset(cfg_offset), .cfg_mask(cfg_mask), .cfg_expect(cfg_expect),
        .cfg_invert(cfg_invert), .cfg_mode(cfg_mode),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .cond_bcast(cond_bcast), .cond_hash(cond_hash), .cond_mcast(cond_mcast),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic kind, input logic [7:0] seed, input int i);
        logic [7:0] src [0:5];
        src = '{8'h00, 8'h04, 8'hA3, 8'hFF, 8'hFF, 8'hFF};
        if (kind && i < 6)  return 8'hFF;
        if (kind && i < 12) return src[i-6];
        return 8'((int'(seed) * 29) + (i * 7) + ((i >> 3) * 11) + 3);
    endfunction

    // reference checksum from R4/R5
    function automatic logic [15:0] ref_csum(input logic kind, input logic [7:0] seed,
                                             input int len, input int ofs, input logic [63:0] mask);
        int unsigned sum = 0;
        int n = 0;
        logic [7:0] hi = 8'h00;
        for (int k = 0; k < 64; k++) begin
            if ((ofs + k) < len && mask[k]) begin
                if (n % 2 == 0) hi = fbyte(kind, seed, ofs + k);
                else            sum += {16'h0, hi, fbyte(kind, seed, ofs + k)};
                n++;
            end
        end
        if (n % 2 == 1) sum += {16'h0, hi, 8'h00};
        while ((sum >> 16) != 0) sum = (sum & 32'hFFFF) + (sum >> 16);
        return ~sum[15:0];
    endfunction

    // drive one frame; at byte chg_at the configuration is disturbed (R11)
    task automatic send(input logic kind, input logic [7:0] seed, input int len, input int chg_at);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == chg_at) begin
                cfg_expect = ~cfg_expect;
                cfg_mode   = 4'd0;
                cfg_offset = 6'd40;
                cfg_invert = ~cfg_invert;
            end
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_data  = fbyte(kind, seed, i);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {15'd0, dec_valid}, 16'd0);
        check("R1 accept in reset", {15'd0, dec_accept}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {15'd0, dec_valid}, 16'd0);

        check("R5 example checksum", ref_csum(1'b1, 8'd1, 64, 0, 64'hFC0), 16'h5BFC);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] c;
            c = ref_csum(VECS[v].kind, VECS[v].seed, int'(VECS[v].len),
                         int'(VECS[v].ofs), VECS[v].mask);
            cfg_offset = VECS[v].ofs;
            cfg_mask   = VECS[v].mask;
            cfg_expect = VECS[v].hit ? c : (c ^ 16'h0001);
            if (v == 0) cfg_expect = 16'h5BFC;
            cfg_invert = VECS[v].inv;
            cfg_mode   = VECS[v].mode;
            cond_bcast = VECS[v].bc;
            cond_hash  = VECS[v].hs;
            cond_mcast = VECS[v].mc;
            send(VECS[v].kind, VECS[v].seed, int'(VECS[v].len), -1);
            check($sformatf("R2 valid pulse vec %0d", v), {15'd0, dec_valid}, 16'd1);
            check($sformatf("R3-R10 verdict vec %0d", v), {15'd0, dec_accept}, {15'd0, VECS[v].acc});
            @(negedge clk);
            check($sformatf("R2 pulse ends vec %0d", v), {15'd0, dec_valid}, 16'd0);
            check($sformatf("R2 accept drops vec %0d", v), {15'd0, dec_accept}, 16'd0);
        end

        // R11: configuration disturbed mid-frame does not affect the frame
        cfg_offset = 6'd2; cfg_mask = '1; cfg_invert = 1'b0; cfg_mode = 4'd1;
        cfg_expect = ref_csum(1'b0, 8'd5, 100, 2, '1);
        send(1'b0, 8'd5, 100, 10);
        check("R11 mid-frame change ignored", {15'd0, dec_accept}, 16'd1);
        @(negedge clk);
        // next frame takes the disturbed configuration: mode 0000 rejects (R9)
        send(1'b0, 8'd5, 100, -1);
        check("R11 new config applies", {15'd0, dec_valid & ~dec_accept}, 16'd1);
        @(negedge clk);

        // R2: one-byte frame (start and end together); window cannot complete (R7)
        cfg_offset = 6'd0; cfg_mask = '0; cfg_invert = 1'b1; cfg_mode = 4'd1;
        send(1'b0, 8'd1, 1, -1);
        check("R2 single-byte valid", {15'd0, dec_valid}, 16'd1);
        check("R7 single-byte reject", {15'd0, dec_accept}, 16'd0);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule